// File: doc/BRIEF.md
# Isochronous Source Packet Unpacker

This block sits behind an isochronous receive path. Each bus packet arrives as a run of 32-bit quadlets. The first two quadlets form the common isochronous packet header, and data-block quadlets follow them. The block captures the first header quadlet and decodes three things from it: the data-block size, the number of blocks per source packet, and the count of dummy quadlets. It then gathers data blocks, possibly spread across several bus packets, until a whole source packet is held in a local buffer. Only then does it release that packet, one quadlet per cycle, on an application-side output.

Dummy quadlets at the tail of each source packet are never written to the buffer. The last real quadlet carries an end-of-packet strobe and a byte-valid mask, which hides a programmable number of pad bytes. A small control register holds the receive enable, the drop-unreliable switch, the pad-byte count, a timestamp-enable bit and a receiver reset bit. Its image also reports whether a complete source packet is waiting.

The packet-level behaviour is a four-state machine:
- IDLE waits for a start quadlet.
- HDR2 skips the second header quadlet.
- DATA consumes data quadlets.
- SKIP ignores a rejected packet until its last quadlet.

A start quadlet is taken from any state:
- SOP_ACCEPT leads to HDR2.
- SOP_REJECT leads to SKIP.
- SOP_SHORT leads to IDLE, when the start quadlet is also the last one.

Inside a packet:
- HDR_DONE goes from HDR2 to DATA.
- PKT_END goes from HDR2, DATA or SKIP to IDLE.
- RX_CLEAR forces IDLE from anywhere.

Top module: `iso_sp_unpacker`

## Requirements
- R1: The control image resets to 0x41. Its bit positions are: bit 6 drop-unreliable, bit 5 packet-available (read-only), bit 4 enable, bits 3:2 pad-byte count, bit 1 timestamp enable, bit 0 receiver reset. A write loads every bit except bit 5.
- R2: When a packet starts while enabled, its first quadlet is captured and shown on `hdr_image`. At all other times `hdr_image` holds its value.
- R3: A start quadlet whose bits 31:30 are not 00 causes the whole bus packet to be ignored. Any partly assembled source packet is discarded.
- R4: Data-block size is taken from bits 23:16, and the value 0 stands for 256 quadlets.
- R5: Bits 15:14 select 1, 2, 4 or 8 blocks per source packet (codes 00, 01, 10, 11). Nothing of a source packet appears on the output until all of its quadlets have arrived, even across bus packets.
- R6: The count in bits 13:11 gives the number of trailing dummy quadlets, which are never delivered.
- R7: Non-final output quadlets carry mask 4'hF. The final quadlet carries `out_eop` and a mask for pad count 0/1/2/3 of 4'hF/4'hE/4'hC/4'h8, where bit 3 marks bits 31:24.
- R8: The enable is looked at only on a start quadlet. Clearing it mid-packet does not truncate that packet, and setting it mid-packet does not admit that packet.
- R9: With drop-unreliable set, a packet whose `bus_unrel` is high on its start quadlet is ignored and any partial source packet is discarded. With drop-unreliable clear, such a packet is delivered.
- R10: `pkt_avail` (and image bit 5) is high whenever at least one complete source packet sits in the buffer undelivered.
- R11: A source packet larger than the free buffer space is discarded, and later packets are unaffected.
- R12: While the reset bit is set, the receiver returns to IDLE and empties its buffer and partial packet.
- R13: The second header quadlet is never delivered, and data begins with the third quadlet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 7 | Control register write value |
| ctl_image | output | 7 | Control and status image |
| hdr_image | output | 32 | Last captured first header quadlet |
| bus_valid | input | 1 | Bus quadlet present |
| bus_sop | input | 1 | Quadlet is the first of a bus packet |
| bus_eop | input | 1 | Quadlet is the last of a bus packet |
| bus_unrel | input | 1 | Packet flagged unreliable (read with the start quadlet) |
| bus_data | input | 32 | Bus quadlet |
| out_valid | output | 1 | Output quadlet present |
| out_data | output | 32 | Output quadlet |
| out_bmask | output | 4 | Byte-valid mask of the output quadlet |
| out_eop | output | 1 | Last quadlet of a source packet |
| pkt_avail | output | 1 | A complete source packet is buffered |

## Verification
The in-line assertions check several properties on every cycle:
- the buffer fill never exceeds its depth;
- the read side never passes the committed boundary;
- every non-final output quadlet is fully valid;
- output only follows a cycle with a packet available;
- the receiver reset returns the machine to IDLE;
- the captured header stays put between accepted starts.

Only the directed scenarios can show the end-to-end content rules. These are reassembly of blocks split across bus packets, the quadlet count after dummy removal, the pad masks, the enable sampling point, the discard of partial packets on drop, bad format, overflow and reset, and the 256-quadlet block size.

// File: rtl/spu_pkg.sv
package spu_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_HDR2, ST_DATA, ST_SKIP} asm_state_t;

    typedef struct packed {
        logic        eop;
        logic [3:0]  bmask;
        logic [31:0] data;
    } qword_t;

    localparam int CTL_W      = 7;
    localparam int CB_RST     = 0;
    localparam int CB_SYT     = 1;
    localparam int CB_PAD_LO  = 2;
    localparam int CB_EN      = 4;
    localparam int CB_AVAIL   = 5;
    localparam int CB_DROP    = 6;
    localparam logic [CTL_W-1:0] CTL_RESET = 7'h41;

    function automatic logic [3:0] pad_mask(input logic [1:0] pad);
        unique case (pad)
            2'd0: pad_mask = 4'hF;
            2'd1: pad_mask = 4'hE;
            2'd2: pad_mask = 4'hC;
            2'd3: pad_mask = 4'h8;
        endcase
    endfunction
endpackage

// File: rtl/spu_ctrl_regs.sv
module spu_ctrl_regs
    import spu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CTL_W-1:0] cfg_wdata,
    input  logic             pkt_avail,
    output logic [CTL_W-1:0] ctl_image,
    output logic             en,
    output logic             drop_unrel,
    output logic [1:0]       pad_bytes,
    output logic             rx_clr
);
    logic [CTL_W-1:0] ctl_q;
    localparam logic [CTL_W-1:0] WR_MASK = ~(CTL_W'(1) << CB_AVAIL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl_q <= CTL_RESET;
        else if (cfg_we) ctl_q <= cfg_wdata & WR_MASK;
    end

    always_comb begin
        ctl_image           = ctl_q;
        ctl_image[CB_AVAIL] = pkt_avail;
    end

    assign en         = ctl_q[CB_EN];
    assign drop_unrel = ctl_q[CB_DROP];
    assign pad_bytes  = ctl_q[CB_PAD_LO +: 2];
    assign rx_clr     = ctl_q[CB_RST];

    // R1: bit 5 of the image always follows the buffer status
    assert_avail_image_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_image[CB_AVAIL] == pkt_avail);
endmodule

// File: rtl/spu_assembler.sv
module spu_assembler
    import spu_pkg::*;
#(
    parameter int QW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_clr,
    input  logic          en,
    input  logic          drop_unrel,
    input  logic [1:0]    pad_bytes,
    input  logic          bus_valid,
    input  logic          bus_sop,
    input  logic          bus_eop,
    input  logic          bus_unrel,
    input  logic [QW-1:0] bus_data,
    input  logic          buf_full,
    output logic [QW-1:0] hdr_q1,
    output logic          wr_en,
    output qword_t        wr_word,
    output logic          commit,
    output logic          rollback
);
    localparam int IW = 12;

    asm_state_t    state, state_nxt;
    logic [IW-1:0] sp_idx;
    logic          ovf;

    logic [8:0]    blk_len;
    logic [IW-1:0] sp_len, real_len, qpc_w;
    logic          no_real, start, fmt_ok, drop_now, data_beat, last_real, sp_end;

    always_comb begin
        blk_len   = (hdr_q1[23:16] == 8'd0) ? 9'd256 : {1'b0, hdr_q1[23:16]};
        sp_len    = IW'(blk_len) << hdr_q1[15:14];
        qpc_w     = IW'(hdr_q1[13:11]);
        no_real   = (sp_len <= qpc_w);
        real_len  = sp_len - qpc_w;
        start     = bus_valid && bus_sop;
        fmt_ok    = (bus_data[31:30] == 2'b00);
        drop_now  = start && en && (!fmt_ok || (bus_unrel && drop_unrel));
        data_beat = (state == ST_DATA) && bus_valid && !bus_sop;
        last_real = (sp_idx == real_len - IW'(1));
        sp_end    = data_beat && (sp_idx == sp_len - IW'(1));
    end

    // next-state process
    always_comb begin
        state_nxt = state;
        if (start) begin
            if (bus_eop)              state_nxt = ST_IDLE;
            else if (!en || drop_now) state_nxt = ST_SKIP;
            else                      state_nxt = ST_HDR2;
        end else if (bus_valid) begin
            unique case (state)
                ST_IDLE: state_nxt = ST_IDLE;
                ST_HDR2: state_nxt = bus_eop ? ST_IDLE : ST_DATA;
                ST_DATA: state_nxt = bus_eop ? ST_IDLE : ST_DATA;
                ST_SKIP: state_nxt = bus_eop ? ST_IDLE : ST_SKIP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state <= ST_IDLE;
        else if (rx_clr) state <= ST_IDLE;
        else             state <= state_nxt;
    end

    // output process
    always_comb begin
        wr_en         = data_beat && !no_real && (sp_idx < real_len);
        wr_word.data  = bus_data;
        wr_word.eop   = last_real;
        wr_word.bmask = last_real ? pad_mask(pad_bytes) : 4'hF;
        commit        = sp_end && !ovf && !(wr_en && buf_full) && !no_real;
        rollback      = drop_now || (sp_end && !commit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q1 <= '0;
            sp_idx <= '0;
            ovf    <= 1'b0;
        end else if (rx_clr) begin
            hdr_q1 <= '0;
            sp_idx <= '0;
            ovf    <= 1'b0;
        end else begin
            if (start && en) hdr_q1 <= bus_data;
            if (drop_now) begin
                sp_idx <= '0;
                ovf    <= 1'b0;
            end else if (data_beat) begin
                if (sp_end) begin
                    sp_idx <= '0;
                    ovf    <= 1'b0;
                end else begin
                    sp_idx <= sp_idx + IW'(1);
                    if (wr_en && buf_full) ovf <= 1'b1;
                end
            end
        end
    end

    assert_idle_after_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr |=> (state == ST_IDLE && sp_idx == '0));

    assert_hdr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_valid && bus_sop && en) && !rx_clr) |=> $stable(hdr_q1));
endmodule

// File: rtl/spu_buffer.sv
module spu_buffer
    import spu_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rx_clr,
    input  logic   wr_en,
    input  qword_t wr_word,
    input  logic   commit,
    input  logic   rollback,
    output logic   full,
    output logic   pkt_avail,
    output logic   out_valid,
    output qword_t out_word
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] DEPTH_P = (AW+1)'(DEPTH);

    qword_t      mem [DEPTH];
    logic [AW:0] wr_ptr, cm_ptr, rd_ptr, pkt_cnt, fill, wr_next;
    logic        wr_go, rd_go, rd_eop;

    always_comb begin
        fill      = wr_ptr - rd_ptr;
        full      = (fill == DEPTH_P);
        wr_go     = wr_en && !full;
        wr_next   = wr_ptr + (AW+1)'(wr_go);
        rd_go     = (rd_ptr != cm_ptr);
        rd_eop    = rd_go && mem[rd_ptr[AW-1:0]].eop;
        pkt_avail = (pkt_cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (wr_go) mem[wr_ptr[AW-1:0]] <= wr_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0; cm_ptr <= '0; rd_ptr <= '0; pkt_cnt <= '0;
            out_valid <= 1'b0; out_word <= '0;
        end else if (rx_clr) begin
            wr_ptr <= '0; cm_ptr <= '0; rd_ptr <= '0; pkt_cnt <= '0;
            out_valid <= 1'b0;
        end else begin
            if (rollback)    wr_ptr <= cm_ptr;
            else             wr_ptr <= wr_next;
            if (commit)      cm_ptr <= wr_next;
            out_valid <= rd_go;
            if (rd_go) begin
                out_word <= mem[rd_ptr[AW-1:0]];
                rd_ptr   <= rd_ptr + (AW+1)'(1);
            end
            pkt_cnt <= pkt_cnt + (AW+1)'(commit) - (AW+1)'(rd_eop);
        end
    end

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= DEPTH_P);

    assert_read_within_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_ptr - rd_ptr) <= fill);

    assert_full_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_word.eop) |-> out_word.bmask == 4'hF);

    assert_avail_before_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(pkt_avail));
endmodule

// File: rtl/iso_sp_unpacker.sv
module iso_sp_unpacker
    import spu_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [6:0]  cfg_wdata,
    output logic [6:0]  ctl_image,
    output logic [31:0] hdr_image,
    input  logic        bus_valid,
    input  logic        bus_sop,
    input  logic        bus_eop,
    input  logic        bus_unrel,
    input  logic [31:0] bus_data,
    output logic        out_valid,
    output logic [31:0] out_data,
    output logic [3:0]  out_bmask,
    output logic        out_eop,
    output logic        pkt_avail
);
    logic       en, drop_unrel, rx_clr, buf_full, wr_en, commit, rollback;
    logic [1:0] pad_bytes;
    qword_t     wr_word, out_word;

    spu_ctrl_regs u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .pkt_avail(pkt_avail), .ctl_image(ctl_image), .en(en),
        .drop_unrel(drop_unrel), .pad_bytes(pad_bytes), .rx_clr(rx_clr)
    );

    spu_assembler #(.QW(32)) u_asm (
        .clk(clk), .rst_n(rst_n), .rx_clr(rx_clr), .en(en),
        .drop_unrel(drop_unrel), .pad_bytes(pad_bytes),
        .bus_valid(bus_valid), .bus_sop(bus_sop), .bus_eop(bus_eop),
        .bus_unrel(bus_unrel), .bus_data(bus_data), .buf_full(buf_full),
        .hdr_q1(hdr_image), .wr_en(wr_en), .wr_word(wr_word),
        .commit(commit), .rollback(rollback)
    );

    spu_buffer #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .rx_clr(rx_clr), .wr_en(wr_en),
        .wr_word(wr_word), .commit(commit), .rollback(rollback),
        .full(buf_full), .pkt_avail(pkt_avail),
        .out_valid(out_valid), .out_word(out_word)
    );

    assign out_data  = out_word.data;
    assign out_bmask = out_word.bmask;
    assign out_eop   = out_word.eop;
endmodule

// File: tb/iso_sp_unpacker_bench.sv
module iso_sp_unpacker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_wdata = '0;
    logic [6:0]  ctl_image;
    logic [31:0] hdr_image;
    logic        bus_valid = 1'b0, bus_sop = 1'b0, bus_eop = 1'b0, bus_unrel = 1'b0;
    logic [31:0] bus_data = '0;
    logic        out_valid, out_eop, pkt_avail;
    logic [31:0] out_data;
    logic [3:0]  out_bmask;

    int checks = 0;
    int fails  = 0;
    bit avail_seen = 0;
    logic [36:0] got_q[$];
    logic [36:0] exp_q[$];

    always #10 clk = ~clk;

    iso_sp_unpacker u_iso_sp_unpacker (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .ctl_image(ctl_image), .hdr_image(hdr_image),
        .bus_valid(bus_valid), .bus_sop(bus_sop), .bus_eop(bus_eop),
        .bus_unrel(bus_unrel), .bus_data(bus_data),
        .out_valid(out_valid), .out_data(out_data), .out_bmask(out_bmask),
        .out_eop(out_eop), .pkt_avail(pkt_avail)
    );

    always @(negedge clk) begin
        if (out_valid) got_q.push_back({out_eop, out_bmask, out_data});
        if (pkt_avail) avail_seen = 1;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] hdr(input logic [7:0] dbs, input logic [1:0] fn,
                                        input logic [2:0] qpc);
        return {2'b00, 6'h05, dbs, fn, qpc, 11'h000};
    endfunction

    task automatic wr_ctl(input logic [6:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic send(input logic [31:0] q1, input int n, input logic [31:0] base,
                        input logic unrel, input int tog_at, input logic [6:0] tog_val);
        @(negedge clk);
        bus_valid = 1; bus_sop = 1; bus_eop = 0; bus_unrel = unrel; bus_data = q1;
        @(negedge clk);
        bus_sop = 0; bus_unrel = 0; bus_data = 32'hAAAA_0000; bus_eop = (n == 0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_data = base + i; bus_eop = (i == n - 1);
            cfg_we = (i == tog_at); cfg_wdata = tog_val;
        end
        @(negedge clk);
        bus_valid = 0; bus_eop = 0; cfg_we = 0;
    endtask

    task automatic exp_sp(input logic [31:0] base, input int n, input logic [3:0] last_mask);
        for (int i = 0; i < n; i++)
            exp_q.push_back({(i == n - 1), (i == n - 1) ? last_mask : 4'hF, base + i});
    endtask

    task automatic drain_cmp(input string req, input int waitc);
        repeat (waitc) @(negedge clk);
        chk({req, " count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
            chk(req, got_q[i], exp_q[i]);
        got_q.delete(); exp_q.delete();
    endtask

    task automatic t_reset;   // R1, R12
        chk("R1 ctl reset", ctl_image, 7'h41);
        chk("R1 out idle", {out_valid, pkt_avail}, 2'b00);
        chk("R2 hdr reset", hdr_image, 32'h0);
        send(hdr(8'd4, 2'd0, 3'd0), 4, 32'h0900, 0, -1, 0);
        drain_cmp("R12 held in reset", 10);
        wr_ctl(7'h50);
        chk("R1 ctl write", ctl_image, 7'h50);
    endtask

    task automatic t_simple;  // R2, R10, R13
        avail_seen = 0;
        send(hdr(8'd4, 2'd0, 3'd0), 4, 32'h1000, 0, -1, 0);
        exp_sp(32'h1000, 4, 4'hF);
        drain_cmp("R13 single block", 20);
        chk("R2 header image", hdr_image, hdr(8'd4, 2'd0, 3'd0));
        chk("R10 avail seen", avail_seen, 1);
        chk("R10 avail clear", pkt_avail, 0);
    endtask

    task automatic t_fraction; // R5
        send(hdr(8'd2, 2'd1, 3'd0), 2, 32'h2000, 0, -1, 0);
        repeat (10) @(negedge clk);
        chk("R5 no partial out", got_q.size(), 0);
        send(hdr(8'd2, 2'd1, 3'd0), 2, 32'h2002, 0, -1, 0);
        exp_sp(32'h2000, 4, 4'hF);
        drain_cmp("R5 two blocks", 20);
    endtask

    task automatic t_dummy;   // R6, R7
        wr_ctl(7'h58);
        send(hdr(8'd3, 2'd1, 3'd2), 3, 32'h3000, 0, -1, 0);
        send(hdr(8'd3, 2'd1, 3'd2), 3, 32'h3003, 0, -1, 0);
        exp_sp(32'h3000, 4, 4'hC);
        drain_cmp("R6 dummy strip pad2", 20);
        wr_ctl(7'h5C);
        send(hdr(8'd2, 2'd0, 3'd0), 2, 32'h3100, 0, -1, 0);
        exp_sp(32'h3100, 2, 4'h8);
        drain_cmp("R7 pad3 mask", 20);
        wr_ctl(7'h54);
        send(hdr(8'd1, 2'd2, 3'd1), 1, 32'h3200, 0, -1, 0);
        send(hdr(8'd1, 2'd2, 3'd1), 1, 32'h3201, 0, -1, 0);
        send(hdr(8'd1, 2'd2, 3'd1), 1, 32'h3202, 0, -1, 0);
        send(hdr(8'd1, 2'd2, 3'd1), 1, 32'h3203, 0, -1, 0);
        exp_sp(32'h3200, 3, 4'hE);
        drain_cmp("R7 pad1 four blocks", 20);
        wr_ctl(7'h50);
    endtask

    task automatic t_dbs0;    // R4
        send(hdr(8'd0, 2'd0, 3'd0), 256, 32'h4000, 0, -1, 0);
        exp_sp(32'h4000, 256, 4'hF);
        drain_cmp("R4 size 256", 300);
    endtask

    task automatic t_enable;  // R8
        send(hdr(8'd4, 2'd0, 3'd0), 4, 32'h5000, 0, 1, 7'h40);
        send(hdr(8'd4, 2'd0, 3'd0), 4, 32'h5100, 0, -1, 0);
        send(hdr(8'd4, 2'd0, 3'd0), 4, 32'h5200, 0, 1, 7'h50);
        exp_sp(32'h5000, 4, 4'hF);
        drain_cmp("R8 enable at start only", 20);
        send(hdr(8'd4, 2'd0, 3'd0), 4, 32'h5300, 0, -1, 0);
        exp_sp(32'h5300, 4, 4'hF);
        drain_cmp("R8 re-enabled", 20);
    endtask

    task automatic t_unrel;   // R9
        send(hdr(8'd2, 2'd1, 3'd0), 2, 32'h6000, 0, -1, 0);
        send(hdr(8'd2, 2'd1, 3'd0), 2, 32'h6100, 1, -1, 0);
        send(hdr(8'd2, 2'd1, 3'd0), 2, 32'h6200, 0, -1, 0);
        send(hdr(8'd2, 2'd1, 3'd0), 2, 32'h6202, 0, -1, 0);
        exp_sp(32'h6200, 4, 4'hF);
        drain_cmp("R9 drop unreliable", 20);
        wr_ctl(7'h10);
        send(hdr(8'd4, 2'd0, 3'd0), 4, 32'h6300, 1, -1, 0);
        exp_sp(32'h6300, 4, 4'hF);
        drain_cmp("R9 keep unreliable", 20);
        wr_ctl(7'h50);
    endtask

    task automatic t_format;  // R3
        send(hdr(8'd2, 2'd1, 3'd0), 2, 32'h6800, 0, -1, 0);
        send(hdr(8'd4, 2'd0, 3'd0) | 32'h4000_0000, 4, 32'h6900, 0, -1, 0);
        send(hdr(8'd2, 2'd1, 3'd0), 2, 32'h6A00, 0, -1, 0);
        send(hdr(8'd2, 2'd1, 3'd0), 2, 32'h6A02, 0, -1, 0);
        exp_sp(32'h6A00, 4, 4'hF);
        drain_cmp("R3 bad format", 20);
    endtask

    task automatic t_overflow; // R11
        send(hdr(8'd0, 2'd3, 3'd0), 2048, 32'h7000, 0, -1, 0);
        send(hdr(8'd4, 2'd0, 3'd0), 4, 32'h7800, 0, -1, 0);
        exp_sp(32'h7800, 4, 4'hF);
        drain_cmp("R11 overflow discard", 40);
    endtask

    task automatic t_rxrst;   // R12
        send(hdr(8'd2, 2'd1, 3'd0), 2, 32'h8000, 0, -1, 0);
        wr_ctl(7'h51);
        chk("R12 reset bit image", ctl_image, 7'h51);
        wr_ctl(7'h50);
        send(hdr(8'd2, 2'd1, 3'd0), 2, 32'h8100, 0, -1, 0);
        send(hdr(8'd2, 2'd1, 3'd0), 2, 32'h8102, 0, -1, 0);
        exp_sp(32'h8100, 4, 4'hF);
        drain_cmp("R12 partial discarded", 20);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_simple();
        t_fraction();
        t_dummy();
        t_dbs0();
        t_enable();
        t_unrel();
        t_format();
        t_overflow();
        t_rxrst();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule